// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a free-running 3-bit counter. It visits five codes in a fixed order that is not binary order, and it advances once on every rising clock edge. The three codes outside the cycle each have a defined successor, and each of them reaches the cycle within two clocks. The counter therefore recovers from any power-up value without outside help. The output is the registered state itself, with bit 2 as the most significant bit and bit 0 as the least significant bit.

An active-high synchronous reset puts the counter at 000. A separate seed port lets a test environment place any of the eight codes into the state register. This is the only way to reach the unused codes after the chip has powered up.

Top module: `self_start_seq_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 000 at that edge, whatever the other inputs are.
- R2: With `rst` and `seed_en` low, the cycle codes advance one step per edge in the order 000, 010, 011, 101, 110, and then back to 000.
- R3: With no control active, unused code 001 advances to 110.
- R4: With no control active, unused code 100 advances to 010.
- R5: With no control active, unused code 111 advances to 100 and then to 010.
- R6: From any of the eight codes, with no control active, the state is a cycle code after at most two edges. A cycle code is never followed by a code outside the cycle.
- R7: When `seed_en` is high and `rst` is low at an edge, the state takes `seed_val` at that edge instead of advancing.
- R8: For every code, the successor equals the equations C+ = A, B+ = B' + A'C', and A+ = BC', where C is bit 2, B is bit 1 and A is bit 0 of `state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high, sets the state to 000 |
| seed_en | input | 1 | Test hook: load `seed_val` in place of advancing |
| seed_val | input | 3 | Code to load when `seed_en` is high |
| state | output | 3 | Registered counter state {C,B,A} |

## Verification
The hardest condition to reach from the ports is an unused code. Reset only gives 000, and normal counting never leaves the cycle, so a recovery path can never be seen in ordinary operation. The stimulus therefore uses the seed hook to place each of the eight codes in the register. It then releases the hook and follows the free-running successors for several edges. Each successor is compared against a table of transitions held in the bench.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

  localparam int CODE_W = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t HOME_CODE = 3'b000;

  // Next code from the fixed Boolean equations; c = bit 2, a = bit 0.
  function automatic code_t eqn_next(input code_t cur);
    logic c, b, a;
    c = cur[2];
    b = cur[1];
    a = cur[0];
    return {a, (~b) | (~a & ~c), b & ~c};
  endfunction

  // Membership in the five-code cycle, written as a code list.
  function automatic logic is_cycle_code(input code_t cur);
    return (cur == 3'b000) || (cur == 3'b010) || (cur == 3'b011) ||
           (cur == 3'b101) || (cur == 3'b110);
  endfunction

  // Intended cycle successor, written as a table for cross-checking.
  function automatic code_t cycle_succ(input code_t cur);
    case (cur)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/seqcnt_next.sv
module seqcnt_next
  import seqcnt_pkg::*;
(
  input  code_t cur_code,
  output code_t nxt_code,
  output logic  cur_in_cycle
);

  assign nxt_code     = eqn_next(cur_code);
  assign cur_in_cycle = is_cycle_code(cur_code);

endmodule

// File: rtl/seqcnt_reg.sv
module seqcnt_reg
  import seqcnt_pkg::*;
#(
  parameter code_t RESET_CODE = HOME_CODE
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  seed_en,
  input  code_t seed_val,
  input  code_t adv_code,
  output code_t q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= RESET_CODE;
    else if (seed_en)
      q <= seed_val;
    else
      q <= adv_code;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) rst |=> q == RESET_CODE);

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    seed_en |=> q == $past(seed_val));

endmodule

// File: rtl/self_start_seq_counter.sv
module self_start_seq_counter
  import seqcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       seed_en,
  input  logic [2:0] seed_val,
  output logic [2:0] state
);

  code_t cur_q;
  code_t adv_code;
  logic  in_cycle;
  logic  free_step;

  seqcnt_next u_next (
    .cur_code     (cur_q),
    .nxt_code     (adv_code),
    .cur_in_cycle (in_cycle)
  );

  seqcnt_reg #(.RESET_CODE(HOME_CODE)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .seed_en  (seed_en),
    .seed_val (seed_val),
    .adv_code (adv_code),
    .q        (cur_q)
  );

  assign state     = cur_q;
  assign free_step = !rst && !seed_en;

  // R2
  cycle_order_chk: assert property (@(posedge clk) disable iff (rst)
    (free_step && in_cycle) |=> state == cycle_succ($past(state)));

  // R3
  unused_001_chk: assert property (@(posedge clk) disable iff (rst)
    (free_step && state == 3'b001) |=> state == 3'b110);

  // R4
  unused_100_chk: assert property (@(posedge clk) disable iff (rst)
    (free_step && state == 3'b100) |=> state == 3'b010);

  // R5
  unused_111_chk: assert property (@(posedge clk) disable iff (rst)
    (free_step && state == 3'b111) |=> state == 3'b100);

  // R6
  stay_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (free_step && in_cycle) |=> is_cycle_code(state));

endmodule

// File: tb/test_self_start_seq_counter.sv
module test_self_start_seq_counter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seed_en = 1'b0;
  logic [2:0] seed_val = 3'b000;
  logic [2:0] state;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  self_start_seq_counter i_self_start_seq_counter (
    .clk(clk), .rst(rst), .seed_en(seed_en), .seed_val(seed_val), .state(state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model of the transitions, as a lookup.
  function automatic logic [2:0] model_succ(input logic [2:0] s);
    logic [2:0] tbl [8];
    tbl[0] = 3'd2; tbl[1] = 3'd6; tbl[2] = 3'd3; tbl[3] = 3'd5;
    tbl[4] = 3'd2; tbl[5] = 3'd6; tbl[6] = 3'd0; tbl[7] = 3'd4;
    return tbl[s];
  endfunction

  function automatic bit model_valid(input logic [2:0] s);
    return s inside {3'd0, 3'd2, 3'd3, 3'd5, 3'd6};
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: state=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic seed(input logic [2:0] code);
    @(negedge clk);
    seed_en = 1'b1; seed_val = code;
    tick();
    check("R7", state, code);
    @(negedge clk);
    seed_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; seed_en = 1'b1; seed_val = 3'b111;
    tick();
    check("R1", state, 3'b000);
    @(negedge clk);
    rst = 1'b0; seed_en = 1'b0;
  endtask

  task automatic t_cycle;
    logic [2:0] exp_seq [5];
    exp_seq[0] = 3'b010; exp_seq[1] = 3'b011; exp_seq[2] = 3'b101;
    exp_seq[3] = 3'b110; exp_seq[4] = 3'b000;
    for (int lap = 0; lap < 2; lap++)
      for (int k = 0; k < 5; k++) begin
        tick();
        check("R2", state, exp_seq[k]);
      end
  endtask

  task automatic t_unused;
    seed(3'b001); tick(); check("R3", state, 3'b110);
    seed(3'b100); tick(); check("R4", state, 3'b010);
    seed(3'b111); tick(); check("R5", state, 3'b100);
    tick(); check("R5", state, 3'b010);
  endtask

  task automatic t_all_codes;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] exp;
      int steps;
      seed(3'(c));
      exp = 3'(c);
      steps = 0;
      while (!model_valid(exp)) begin
        exp = model_succ(exp);
        steps++;
      end
      // R6: recovery bound of two edges
      n_cmp++;
      if (steps > 2) begin
        n_bad++;
        $display("FAIL R6: code %b needs %0d steps expected <=2", 3'(c), steps);
      end
      exp = 3'(c);
      for (int k = 0; k < 6; k++) begin
        exp = model_succ(exp);
        tick();
        check("R8", state, exp);
        if (k >= 1) check("R6", {2'b00, model_valid(state)}, 3'b001);
      end
    end
  endtask

  task automatic t_seed_override;
    tick();
    seed(3'b011);
    seed(3'b011);
    tick(); check("R2", state, 3'b101);
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R1", state, 3'b000);
    @(negedge clk) rst = 1'b0;
    t_cycle();
    t_unused();
    t_reset();
    t_all_codes();
    t_seed_override();
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: state=%b expected=finish", state);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule